// File: doc/BRIEF.md
# Reloading Interval Timer Channel

This block is a single down-counting timer channel that a processor reaches through a small word-addressed register interface. Software places a start value in the load register, picks an operating mode and a tick source in the control register, and then sets the enable bit. On every cycle in which the selected tick-enable input is high, the counter steps down by one. When a step would take it below zero, it raises a level interrupt that stays high until software writes to the clear register.

Two tick-enable inputs come from outside the block. The control register picks the faster one, which typically runs at around half a megahertz, or the slower one. In periodic mode the counter restarts from the stored load value after each underflow, so a load value of N gives one interrupt every N+1 selected ticks. In free-run mode the counter wraps to all ones and still flags the underflow. The counter width is a parameter. Narrow and full-word instances share the same register map and return zero-extended values.

Top module: `reload_timer`

## Requirements
- R1: After reset the load, value and control registers read 0 and `irq` is low. This holds for a reset applied in the middle of operation as well.
- R2: A write to offset 0x00 stores the low CNT_W bits of the write data as the reload value and also copies them into the counter. That write takes precedence over a tick arriving in the same cycle, and no underflow occurs in that cycle. Reading 0x00 returns the stored reload value.
- R3: While control bit 7 is 1, each cycle in which the selected tick is high decrements a nonzero count by one. Control bit 3 = 1 selects `tick_hi_en` and bit 3 = 0 selects `tick_lo_en`. The tick that is not selected has no effect.
- R4: While control bit 7 is 0, ticks leave the count unchanged, and an interrupt that is already pending stays asserted.
- R5: A selected tick while enabled with the count at 0 sets `irq` one cycle later. With control bit 6 = 1 (periodic), the counter reloads the stored value, so load N yields one interrupt every N+1 ticks.
- R6: With control bit 6 = 0 (free-run), an underflow wraps the counter to all ones (0xFFFF for a 16-bit counter) and still sets `irq`.
- R7: A write of any data to offset 0x0C clears `irq`. An underflow in the same cycle as that write wins, and `irq` stays high. Without such a write, `irq` never falls.
- R8: Reading offset 0x08 returns bits 7, 6 and 3 as written, with all other bits 0.
- R9: Writes to offset 0x04 are ignored. Reading 0x0C returns 0. An address other than 0x00, 0x04, 0x08 or 0x0C reads as 0 and ignores writes.
- R10: `bus_rdata` is registered. It takes the addressed value at the clock edge where `bus_rd` is high and holds that value until the next read.
- R11: Reading 0x04 returns the live count zero-extended to DATA_W. A 32-bit counter keeps all load bits, and a 16-bit counter keeps the low 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DATA_W | Registered read data |
| tick_hi_en | input | 1 | Fast tick enable, used when control bit 3 is 1 |
| tick_lo_en | input | 1 | Slow tick enable, used when control bit 3 is 0 |
| irq | output | 1 | Level interrupt, set on underflow, cleared by a write to 0x0C |

## Verification
The bench builds two copies side by side on the same bus and tick stimulus. One has CNT_W=16 and the other has CNT_W=32, and both use DATA_W=32 and ADDR_W=8. The 16-bit copy exercises the zero-extension path and the truncation of wide load data. The 32-bit copy exercises the generate branch where the count fills the whole data word, so a free-run wrap can be compared against 0xFFFF and against 0xFFFFFFFF under one stimulus. The 8-bit address also brings unmapped offsets above 0x0C within reach, so aliasing can be tested.

// File: rtl/rt_pkg.sv
package rt_pkg;

   localparam int unsigned OFS_LOAD  = 'h00;
   localparam int unsigned OFS_VALUE = 'h04;
   localparam int unsigned OFS_CTRL  = 'h08;
   localparam int unsigned OFS_CLEAR = 'h0C;

   localparam int unsigned CTL_EN_BIT  = 7;
   localparam int unsigned CTL_PER_BIT = 6;
   localparam int unsigned CTL_SRC_BIT = 3;

   typedef enum logic [1:0] {
      REG_LOAD  = 2'd0,
      REG_VALUE = 2'd1,
      REG_CTRL  = 2'd2,
      REG_CLEAR = 2'd3
   } rt_reg_e;

   typedef struct packed {
      logic en;
      logic periodic;
      logic src_hi;
   } rt_ctrl_t;

endpackage

// File: rtl/rt_decode.sv
module rt_decode
   import rt_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   output logic              hit,
   output rt_reg_e           sel,
   output logic              we_load,
   output logic              we_ctrl,
   output logic              we_clear,
   output logic              re_any
);

   logic upper_zero;

   generate
      if (ADDR_W > 4) begin : g_upper
         assign upper_zero = ~|addr[ADDR_W-1:4];
      end else begin : g_exact
         assign upper_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      sel      = rt_reg_e'(addr[3:2]);
      hit      = upper_zero && (addr[1:0] == 2'b00);
      we_load  = wr && hit && (sel == REG_LOAD);
      we_ctrl  = wr && hit && (sel == REG_CTRL);
      we_clear = wr && hit && (sel == REG_CLEAR);
      re_any   = rd;
   end

endmodule

// File: rtl/rt_count.sv
module rt_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             periodic,
   input  logic             src_hi,
   input  logic             tick_hi,
   input  logic             tick_lo,
   input  logic             load_we,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] count,
   output logic             underflow
);

   localparam logic [CNT_W-1:0] WRAP_VAL = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

   logic             sel_tick;
   logic             step;
   logic             at_zero;
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] next_after_zero;

   always_comb begin
      sel_tick        = src_hi ? tick_hi : tick_lo;
      step            = en && sel_tick && !load_we;
      at_zero         = (count_q == '0);
      underflow       = step && at_zero;
      next_after_zero = periodic ? reload : WRAP_VAL;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (load_we) begin
         count_q <= load_val;
      end else if (step) begin
         count_q <= at_zero ? next_after_zero : (count_q - ONE);
      end
   end

   assign count = count_q;

endmodule

// File: rtl/rt_irq.sv
module rt_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic irq
);

   logic irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else if (set) begin
         irq_q <= 1'b1;
      end else if (clr) begin
         irq_q <= 1'b0;
      end
   end

   assign irq = irq_q;

endmodule

// File: rtl/reload_timer.sv
module reload_timer
   import rt_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tick_hi_en,
   input  logic              tick_lo_en,
   output logic              irq
);

   localparam int PAD_W = DATA_W - CNT_W;

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("reload_timer: CNT_W must lie in 2..DATA_W");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("reload_timer: DATA_W must hold control bit 7");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("reload_timer: ADDR_W must reach offset 0x0C");
      end
   endgenerate

   logic             hit;
   rt_reg_e          sel;
   logic             we_load;
   logic             we_ctrl;
   logic             we_clear;
   logic             re_any;
   logic [CNT_W-1:0] wr_val;
   logic [CNT_W-1:0] load_q;
   logic [CNT_W-1:0] count;
   logic             underflow;
   rt_ctrl_t         ctl_q;
   logic             ctl_en;
   logic             ctl_per;
   logic             ctl_src;
   logic [DATA_W-1:0] count_ext;
   logic [DATA_W-1:0] load_ext;
   logic [DATA_W-1:0] ctrl_rd;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;
   wire               unused_wdata = ^bus_wdata;

   assign wr_val  = bus_wdata[CNT_W-1:0];
   assign ctl_en  = ctl_q.en;
   assign ctl_per = ctl_q.periodic;
   assign ctl_src = ctl_q.src_hi;

   rt_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr     (bus_addr),
      .wr       (bus_wr),
      .rd       (bus_rd),
      .hit      (hit),
      .sel      (sel),
      .we_load  (we_load),
      .we_ctrl  (we_ctrl),
      .we_clear (we_clear),
      .re_any   (re_any)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         load_q <= '0;
         ctl_q  <= '0;
      end else begin
         if (we_load) begin
            load_q <= wr_val;
         end
         if (we_ctrl) begin
            ctl_q.en       <= bus_wdata[CTL_EN_BIT];
            ctl_q.periodic <= bus_wdata[CTL_PER_BIT];
            ctl_q.src_hi   <= bus_wdata[CTL_SRC_BIT];
         end
      end
   end

   rt_count #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (ctl_en),
      .periodic  (ctl_per),
      .src_hi    (ctl_src),
      .tick_hi   (tick_hi_en),
      .tick_lo   (tick_lo_en),
      .load_we   (we_load),
      .load_val  (wr_val),
      .reload    (load_q),
      .count     (count),
      .underflow (underflow)
   );

   rt_irq u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (underflow),
      .clr   (we_clear),
      .irq   (irq)
   );

   generate
      if (PAD_W == 0) begin : g_full
         assign count_ext = count;
         assign load_ext  = load_q;
      end else begin : g_pad
         assign count_ext = {{PAD_W{1'b0}}, count};
         assign load_ext  = {{PAD_W{1'b0}}, load_q};
      end
   endgenerate

   always_comb begin
      ctrl_rd              = '0;
      ctrl_rd[CTL_EN_BIT]  = ctl_q.en;
      ctrl_rd[CTL_PER_BIT] = ctl_q.periodic;
      ctrl_rd[CTL_SRC_BIT] = ctl_q.src_hi;
      rd_mux               = '0;
      if (hit) begin
         case (sel)
            REG_LOAD:  rd_mux = load_ext;
            REG_VALUE: rd_mux = count_ext;
            REG_CTRL:  rd_mux = ctrl_rd;
            default:   rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (re_any) begin
         rdata_q <= rd_mux;
      end
   end

   assign bus_rdata = rdata_q;

endmodule

// File: rtl/rt_timer_chk.sv
module rt_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             periodic,
   input logic             src_hi,
   input logic             tick_hi,
   input logic             tick_lo,
   input logic             load_we,
   input logic             clear_we,
   input logic [CNT_W-1:0] load_val,
   input logic [CNT_W-1:0] reload,
   input logic [CNT_W-1:0] count,
   input logic             irq
);

   logic sel;
   logic live_step;
   assign sel       = src_hi ? tick_hi : tick_lo;
   assign live_step = en && sel && !load_we;

   // R2: a load write lands in the counter on the next cycle
   a_r2_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
      load_we |=> (count == $past(load_val)));

   // R3: an enabled selected tick steps a nonzero count down by one
   a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (live_step && count != '0) |=> (count == $past(count) - {{(CNT_W-1){1'b0}}, 1'b1}));

   // R4: disabled and no load write keeps the count frozen
   a_r4_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !load_we) |=> $stable(count));

   // R5: underflow raises the interrupt
   a_r5_underflow_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (live_step && count == '0) |=> irq);

   // R5: periodic underflow restarts from the stored reload value
   a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (live_step && count == '0 && periodic) |=> (count == $past(reload)));

   // R6: free-run underflow wraps to all ones
   a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (live_step && count == '0 && !periodic) |=> (&count));

   // R7: the interrupt only falls after a clear write
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clear_we) |=> irq);

   // R7: a clear write with no concurrent underflow drops the interrupt
   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_we && !(live_step && count == '0)) |=> !irq);

endmodule

bind reload_timer rt_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en       (ctl_en),
   .periodic (ctl_per),
   .src_hi   (ctl_src),
   .tick_hi  (tick_hi_en),
   .tick_lo  (tick_lo_en),
   .load_we  (we_load),
   .clear_we (we_clear),
   .load_val (wr_val),
   .reload   (load_q),
   .count    (count),
   .irq      (irq)
);

// File: tb/tb_reload_timer.sv
module tb_reload_timer;

   localparam logic [1:0] OP_WR = 2'd0;
   localparam logic [1:0] OP_RD = 2'd1;
   localparam logic [1:0] OP_TK = 2'd2;
   localparam logic [1:0] OP_IQ = 2'd3;

   typedef struct packed {
      logic [1:0]  op;
      logic [7:0]  addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 44;
   localparam vec_t VECS [NV] = '{
      '{OP_RD, 8'h00, 32'h0,        32'h0,     4'd1},  // R1 load reset
      '{OP_RD, 8'h04, 32'h0,        32'h0,     4'd1},  // R1 value reset
      '{OP_RD, 8'h08, 32'h0,        32'h0,     4'd1},  // R1 ctrl reset
      '{OP_IQ, 8'h00, 32'h0,        32'h0,     4'd1},  // R1 irq low
      '{OP_WR, 8'h00, 32'h3,        32'h0,     4'd2},
      '{OP_RD, 8'h00, 32'h0,        32'h3,     4'd2},  // R2 reload readback
      '{OP_RD, 8'h04, 32'h0,        32'h3,     4'd2},  // R2 copied to count
      '{OP_WR, 8'h08, 32'hFFFFFFFF, 32'h0,     4'd8},
      '{OP_RD, 8'h08, 32'h0,        32'hC8,    4'd8},  // R8 only 7,6,3
      '{OP_TK, 8'h00, 32'h1,        32'h0,     4'd3},
      '{OP_RD, 8'h04, 32'h0,        32'h2,     4'd3},  // R3 decrement
      '{OP_TK, 8'h00, 32'h0,        32'h0,     4'd3},
      '{OP_RD, 8'h04, 32'h0,        32'h2,     4'd3},  // R3 other tick ignored
      '{OP_TK, 8'h00, 32'h1,        32'h0,     4'd3},
      '{OP_TK, 8'h00, 32'h1,        32'h0,     4'd3},
      '{OP_RD, 8'h04, 32'h0,        32'h0,     4'd3},  // R3 reached zero
      '{OP_IQ, 8'h00, 32'h0,        32'h0,     4'd5},  // R5 no irq before underflow
      '{OP_TK, 8'h00, 32'h1,        32'h0,     4'd5},
      '{OP_RD, 8'h04, 32'h0,        32'h3,     4'd5},  // R5 reload after 4 ticks
      '{OP_IQ, 8'h00, 32'h0,        32'h1,     4'd5},  // R5 irq set
      '{OP_WR, 8'h08, 32'h40,       32'h0,     4'd4},
      '{OP_TK, 8'h00, 32'h1,        32'h0,     4'd4},
      '{OP_RD, 8'h04, 32'h0,        32'h3,     4'd4},  // R4 frozen
      '{OP_IQ, 8'h00, 32'h0,        32'h1,     4'd4},  // R4 irq kept
      '{OP_WR, 8'h0C, 32'hDEAD,     32'h0,     4'd7},
      '{OP_IQ, 8'h00, 32'h0,        32'h0,     4'd7},  // R7 cleared
      '{OP_WR, 8'h04, 32'h55,       32'h0,     4'd9},
      '{OP_RD, 8'h04, 32'h0,        32'h3,     4'd9},  // R9 value write ignored
      '{OP_RD, 8'h0C, 32'h0,        32'h0,     4'd9},  // R9 clear reads 0
      '{OP_RD, 8'h10, 32'h0,        32'h0,     4'd9},  // R9 unmapped reads 0
      '{OP_WR, 8'h10, 32'h77,       32'h0,     4'd9},
      '{OP_RD, 8'h00, 32'h0,        32'h3,     4'd9},  // R9 no alias on load
      '{OP_RD, 8'h08, 32'h0,        32'h40,    4'd8},  // R8 readback
      '{OP_WR, 8'h00, 32'h1,        32'h0,     4'd2},
      '{OP_WR, 8'h08, 32'h80,       32'h0,     4'd6},
      '{OP_TK, 8'h00, 32'h0,        32'h0,     4'd3},
      '{OP_RD, 8'h04, 32'h0,        32'h0,     4'd3},  // R3 slow source
      '{OP_TK, 8'h00, 32'h0,        32'h0,     4'd6},
      '{OP_RD, 8'h04, 32'h0,        32'hFFFF,  4'd6},  // R6 wrap
      '{OP_IQ, 8'h00, 32'h0,        32'h1,     4'd6},  // R6 irq on wrap
      '{OP_TK, 8'h00, 32'h1,        32'h0,     4'd3},
      '{OP_RD, 8'h04, 32'h0,        32'hFFFF,  4'd3},  // R3 fast tick ignored
      '{OP_WR, 8'h0C, 32'h0,        32'h0,     4'd7},
      '{OP_IQ, 8'h00, 32'h0,        32'h0,     4'd7}   // R7 zero data clears
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic        tick_hi_en = 1'b0;
   logic        tick_lo_en = 1'b0;
   logic [31:0] rd16, rd32;
   logic        irq16, irq32;

   int checks = 0;
   int fails  = 0;
   int got    = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   reload_timer #(.ADDR_W(8), .DATA_W(32), .CNT_W(16)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(rd16),
      .tick_hi_en(tick_hi_en), .tick_lo_en(tick_lo_en), .irq(irq16)
   );

   reload_timer #(.ADDR_W(8), .DATA_W(32), .CNT_W(32)) dut_w32 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(rd32),
      .tick_hi_en(tick_hi_en), .tick_lo_en(tick_lo_en), .irq(irq32)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic tick(input bit hi);
      @(negedge clk);
      if (hi) tick_hi_en = 1'b1; else tick_lo_en = 1'b1;
      @(negedge clk);
      tick_hi_en = 1'b0; tick_lo_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         case (VECS[i].op)
            OP_WR: wr(VECS[i].addr, VECS[i].data);
            OP_RD: begin
               rd(VECS[i].addr);
               check($sformatf("R%0d vec%0d", VECS[i].req, i), rd16, VECS[i].exp);
            end
            OP_TK: tick(VECS[i].data[0]);
            default: check($sformatf("R%0d vec%0d irq", VECS[i].req, i), {31'b0, irq16}, VECS[i].exp);
         endcase
      end

      // R6 / R11: wrap value depends on counter width
      rd(8'h04);
      check("R6 wrap 16-bit", rd16, 32'h0000FFFF);
      check("R11 wrap 32-bit", rd32, 32'hFFFFFFFF);

      // R11: load truncation per width
      wr(8'h00, 32'h0001_2345);
      rd(8'h00);
      check("R11 load 16-bit", rd16, 32'h2345);
      check("R11 load 32-bit", rd32, 32'h12345);

      // R2: load write beats a same-cycle tick (ctrl: enabled, free-run, slow)
      @(negedge clk);
      bus_addr = 8'h00; bus_wdata = 32'h9; bus_wr = 1'b1; tick_lo_en = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; tick_lo_en = 1'b0;
      rd(8'h04);
      check("R2 load wins over tick", rd16, 32'h9);

      // R10: read data holds without a read strobe
      tick(1'b0);
      check("R10 rdata held", rd16, 32'h9);
      rd(8'h04);
      check("R10 new read", rd16, 32'h8);

      // R7: underflow in the same cycle as a clear write keeps irq
      wr(8'h00, 32'h0);
      @(negedge clk);
      bus_addr = 8'h0C; bus_wdata = 32'h1; bus_wr = 1'b1; tick_lo_en = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; tick_lo_en = 1'b0;
      check("R7 set beats clear", {31'b0, irq16}, 32'h1);
      wr(8'h0C, 32'h0);
      check("R7 clear after", {31'b0, irq16}, 32'h0);

      // R5: load 2, periodic on the slow source gives irq after 3 ticks
      wr(8'h00, 32'h2);
      wr(8'h08, 32'hC0);
      got = 0;
      for (int k = 1; k <= 6; k++) begin
         tick(1'b0);
         if (irq16 && got == 0) got = k;
      end
      check("R5 period N+1", got, 3);

      // R1: reset in the middle of operation
      check("R1 irq before reset", {31'b0, irq16}, 32'h1);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      check("R1 irq after reset", {31'b0, irq16}, 32'h0);
      rd(8'h00);
      check("R1 load after reset", rd16, 32'h0);
      rd(8'h04);
      check("R1 value after reset", rd16, 32'h0);
      rd(8'h08);
      check("R1 ctrl after reset", rd16, 32'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule